// File: doc/BRIEF.md
# Carry-less polynomial multiply-long unit

This execution unit performs carry-less (GF(2)) multiplication for a SIMD datapath. It receives an instruction word with two 128-bit source vectors, decodes which of two widening multiply forms the instruction asks for, and returns one 128-bit result a cycle later. Partial products are combined with XOR, so no carry ever moves from one bit position into the next.

The byte form splits one 64-bit half of each source into eight bytes. It multiplies byte k of one source by byte k of the other, and the product fills 16-bit lane k of the result. The doubleword form multiplies one 64-bit element of each source and gives a full 128-bit product. A half-select bit in the instruction chooses whether both sources are read from their lower or their upper 64 bits. An instruction that matches neither form is flagged as illegal and produces no result.

Top module: `pmull_unit`

## Requirements
- R1: With instr[30]=0 and instr[23:22]=00, 16-bit result lane k (bits 16k+15:16k) is the carry-less product of byte k of src_a and byte k of src_b, for k in 0..7.
- R2: With instr[30]=1 and instr[23:22]=00, lane k uses byte 8+k of each source instead.
- R3: With instr[30]=0 and instr[23:22]=11, the result is the 128-bit carry-less product of src_a[63:0] and src_b[63:0].
- R4: With instr[30]=1 and instr[23:22]=11, the product uses src_a[127:64] and src_b[127:64]. Product bits above position 63 land in result[127:64].
- R5: A multiplier of 1 returns the multiplicand unchanged and zero-extended. A shift of zero adds nothing to the upper part of the product.
- R6: Bit 15 of every byte-form lane is zero, and bit 127 of every doubleword-form result is zero.
- R7: A legal instruction has instr[29:24]=001110, instr[21]=1, instr[15:10]=111000 and instr[23:22] set to 00 or 11. All other fields are ignored. Any other word presented with in_valid pulses bad_op for one cycle, keeps out_valid low and leaves result unchanged.
- R8: out_valid rises exactly one cycle after in_valid with a legal instruction. With in_valid low, out_valid and bad_op stay low on the next cycle and result is held.
- R9: During and right after reset, out_valid, bad_op and result are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction and operands present |
| instr | input | 32 | Instruction word to decode |
| src_a | input | 2*WIDE_W | First source vector |
| src_b | input | 2*WIDE_W | Second source vector |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| bad_op | output | 1 | Illegal instruction seen on the previous cycle |
| result | output | 2*WIDE_W | Registered product |

## Verification
The bench builds the unit with its default widths: 8-bit narrow elements inside a 64-bit half, giving a 128-bit vector. At these widths every corner named above can be reached. These include an all-ones doubleword pair, whose product reaches bit 126 and fills the upper word. A multiplier of one exercises the zero shift. Opposite-half operands expose a wrong half select. Illegal words differ from a legal one in a single fixed bit. Back-to-back streams check that no stage stalls between operations.

// File: rtl/pmull_unit.sv
module pmull_unit #(
  parameter int NARROW_W = 8,
  parameter int WIDE_W   = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [31:0]         instr,
  input  logic [2*WIDE_W-1:0] src_a,
  input  logic [2*WIDE_W-1:0] src_b,
  output logic                out_valid,
  output logic                bad_op,
  output logic [2*WIDE_W-1:0] result
);
  localparam int VEC_W  = 2 * WIDE_W;
  localparam int LANES  = WIDE_W / NARROW_W;
  localparam int PROD_W = 2 * NARROW_W;

  function automatic logic [VEC_W-1:0] lane_top_mask();
    logic [VEC_W-1:0] m;
    m = '0;
    for (int k = 0; k < LANES; k++) m[k*PROD_W + PROD_W-1] = 1'b1;
    return m;
  endfunction
  localparam logic [VEC_W-1:0] LANE_TOP = lane_top_mask();

  function automatic logic [PROD_W-1:0] clmul_n(input logic [NARROW_W-1:0] x,
                                                input logic [NARROW_W-1:0] y);
    logic [PROD_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < NARROW_W; i++)
      if (y[i]) acc = acc ^ ({{NARROW_W{1'b0}}, x} << i);
    return acc;
  endfunction

  function automatic logic [VEC_W-1:0] clmul_w(input logic [WIDE_W-1:0] x,
                                               input logic [WIDE_W-1:0] y);
    logic [VEC_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < WIDE_W; i++)
      if (y[i]) acc = acc ^ ({{WIDE_W{1'b0}}, x} << i);
    return acc;
  endfunction

  logic fixed_ok, is_narrow, is_wide, legal, upper;
  assign fixed_ok  = (instr[29:24] == 6'b001110) && instr[21] && (instr[15:10] == 6'b111000);
  assign is_narrow = fixed_ok && (instr[23:22] == 2'b00);
  assign is_wide   = fixed_ok && (instr[23:22] == 2'b11);
  assign legal     = is_narrow || is_wide;
  assign upper     = instr[30];

  logic [WIDE_W-1:0] a_half, b_half;
  assign a_half = upper ? src_a[VEC_W-1:WIDE_W] : src_a[WIDE_W-1:0];
  assign b_half = upper ? src_b[VEC_W-1:WIDE_W] : src_b[WIDE_W-1:0];

  logic [VEC_W-1:0] narrow_prod, wide_prod;
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign narrow_prod[g*PROD_W +: PROD_W] =
      clmul_n(a_half[g*NARROW_W +: NARROW_W], b_half[g*NARROW_W +: NARROW_W]);
  end
  assign wide_prod = clmul_w(a_half, b_half);

  logic wide_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      bad_op    <= 1'b0;
      wide_q    <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid && legal;
      bad_op    <= in_valid && !legal;
      if (in_valid && legal) begin
        wide_q <= is_wide;
        result <= is_wide ? wide_prod : narrow_prod;
      end
    end
  end

  AST_LANE_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !wide_q) |-> ((result & LANE_TOP) == '0)); // R6
  AST_WIDE_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && wide_q) |-> !result[VEC_W-1]); // R6
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({out_valid, bad_op})); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !bad_op)); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result)); // R8
  AST_BAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bad_op |-> $stable(result)); // R7
endmodule

// File: tb/pmull_unit_tb.sv
module pmull_unit_tb_top;
  localparam int VW = 128;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [VW-1:0] src_a = '0, src_b = '0;
  logic out_valid, bad_op;
  logic [VW-1:0] result;

  always #2 clk = ~clk;

  pmull_unit dut_i (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
    .src_a(src_a), .src_b(src_b), .out_valid(out_valid), .bad_op(bad_op), .result(result));

  typedef struct packed { logic bad; logic [VW-1:0] res; logic [7:0] tag; } item_t;
  item_t sbq[$];
  int tests = 0, fails = 0;
  logic [VW-1:0] last_good = '0;
  logic [63:0] lfsr = 64'h9E37_79B9_7F4A_7C15;

  task automatic check(input bit ok, input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [VW-1:0] ref_mul(input logic [63:0] x, input logic [63:0] y, input int w);
    logic [VW-1:0] acc = '0;
    for (int i = w - 1; i >= 0; i--) begin
      acc = acc << 1;
      if (y[i]) acc = acc ^ {64'd0, x};
    end
    return acc;
  endfunction

  function automatic logic [31:0] mk(input bit q, input bit wide, input logic [14:0] regs);
    return {1'b0, q, 6'b001110, wide ? 2'b11 : 2'b00, 1'b1, regs[14:10], 6'b111000, regs[9:0]};
  endfunction

  function automatic logic [VW-1:0] expect_of(input bit q, input bit wide,
                                               input logic [VW-1:0] a, input logic [VW-1:0] b);
    logic [63:0] ha = q ? a[127:64] : a[63:0];
    logic [63:0] hb = q ? b[127:64] : b[63:0];
    logic [VW-1:0] r = '0;
    logic [VW-1:0] t;
    if (wide) return ref_mul(ha, hb, 64);
    for (int k = 0; k < 8; k++) begin
      t = ref_mul({56'd0, ha[k*8 +: 8]}, {56'd0, hb[k*8 +: 8]}, 8);
      r[k*16 +: 16] = t[15:0];
    end
    return r;
  endfunction

  task automatic issue(input logic [31:0] w, input logic [VW-1:0] a, input logic [VW-1:0] b,
                       input bit legal, input bit q, input bit wide, input logic [7:0] tag);
    item_t it;
    in_valid = 1'b1; instr = w; src_a = a; src_b = b;
    it.bad = !legal; it.tag = tag;
    if (legal) begin
      it.res = expect_of(q, wide, a, b);
      last_good = it.res;
    end else it.res = last_good;
    sbq.push_back(it);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic op(input bit q, input bit wide, input logic [VW-1:0] a, input logic [VW-1:0] b, input logic [7:0] tag);
    lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
    issue(mk(q, wide, lfsr[14:0]), a, b, 1'b1, q, wide, tag);
  endtask

  always @(negedge clk) begin
    if (rst_n && (out_valid || bad_op)) begin
      item_t it;
      if (sbq.size() == 0) check(1'b0, "R8 unexpected output", result, '0);
      else begin
        it = sbq.pop_front();
        check(bad_op == it.bad, $sformatf("R7 outcome kind tag%0d", it.tag), {127'd0, bad_op}, {127'd0, it.bad});
        check(result == it.res, $sformatf("R%0d result tag%0d", it.tag, it.tag), result, it.res);
        if (out_valid) begin
          check(!result[127], "R6 top bit", result, it.res);
          for (int k = 0; k < 8; k++)
            if (it.tag <= 2) check(!result[k*16+15], "R6 lane top", result, it.res);
        end
      end
    end
  end

  task automatic drain();
    repeat (3) @(posedge clk);
    #1;
  endtask

  initial begin
    #400000;
    check(1'b0, "watchdog", '0, '0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [VW-1:0] a, b;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!out_valid && !bad_op && result == '0, "R9 in reset", result, '0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    @(negedge clk);
    check(!out_valid && !bad_op && result == '0, "R9 after reset", result, '0);
    @(posedge clk); #1;

    // R1, R2: byte form, both halves, distinct patterns
    op(0, 0, 128'hFFEEDDCCBBAA9988_FF80_7F01_0203_0405, 128'h0102030405060708_FF_FF_80_03_11_22_33_44, 1);
    op(1, 0, 128'hFF80_7F01_C3A5_5A3C_0000000000000000, 128'hFFFF_8080_0201_FFEE_0000000000000000, 2);
    op(0, 0, 128'h0, 128'hFFFFFFFFFFFFFFFF_FFFFFFFFFFFFFFFF, 1);
    // R3, R4: doubleword form
    op(0, 1, 128'h1234_5678_9ABC_DEF0_8000_0000_0000_0001, 128'hFFFF_0000_FFFF_0000_C000_0000_0000_0003, 3);
    op(1, 1, 128'hFFFFFFFFFFFFFFFF_0, 128'hFFFFFFFFFFFFFFFF_0, 4);
    op(1, 1, 128'h8000000000000000_FFFFFFFFFFFFFFFF, 128'h8000000000000000_1, 4);
    // R5: unit multiplier, zero shift
    op(0, 1, 128'h0_DEADBEEFCAFEF00D, 128'h0_1, 5);
    op(1, 1, {64'hFFFFFFFFFFFFFFFF, 64'h0}, {64'h1, 64'hFFFF}, 5);
    op(0, 0, 128'h0_A5A5A5A5A5A5A5A5, 128'h0_0101010101010101, 5);
    drain();
    check(sbq.size() == 0, "R8 latency drain", sbq.size(), 0);

    // R7: illegal words, each differing in one fixed bit or using size 01/10
    issue(mk(0, 1, 15'h1234) ^ 32'h0080_0000, 128'h5, 128'h7, 0, 0, 0, 7);
    issue(mk(0, 0, 15'h0042) ^ 32'h0040_0000, 128'h5, 128'h7, 0, 0, 0, 7);
    issue(mk(1, 0, 15'h7FFF) ^ 32'h0020_0000, 128'h5, 128'h7, 0, 0, 0, 7);
    issue(mk(0, 1, 15'h0000) ^ 32'h0000_0400, 128'h5, 128'h7, 0, 0, 0, 7);
    issue(mk(0, 0, 15'h0000) ^ 32'h0100_0000, 128'h5, 128'h7, 0, 0, 0, 7);
    // R7: ignored fields (bit 31, registers) do not matter
    lfsr = lfsr ^ 64'h55;
    issue(mk(1, 0, 15'h5555) | 32'h8000_0000, 128'hC3C3C3C3C3C3C3C3_0, 128'h3C3C3C3C3C3C3C3C_0, 1, 1, 0, 7);
    drain();

    // R8: idle cycles hold result, no strobes
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(!out_valid && !bad_op && result == last_good, "R8 idle hold", result, last_good);
    end
    @(posedge clk); #1;

    // back-to-back pseudo-random stream, all four forms
    for (int n = 0; n < 40; n++) begin
      lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
      a = {lfsr, ~lfsr ^ 64'h0F0F};
      b = {lfsr * 64'd3, lfsr ^ 64'h1357_9BDF_2468_ACE0};
      op(n[0], n[1], a, b, n[1] ? (n[0] ? 8'd4 : 8'd3) : (n[0] ? 8'd2 : 8'd1));
    end
    drain();
    check(sbq.size() == 0, "R8 stream drain", sbq.size(), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule